// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns eight interrupt input lines into a vector of pending requests. Each line can be set to follow its input level or to latch on a rising transition. It keeps one stored copy of each line's previous sample, and it uses that copy to find rising transitions. A separate mask register marks lines that downstream logic should treat as masked. The mask does not stop a request from being recorded. Its only effect is on the status reported for each event.

The priority logic that sits after this block clears a pending edge request by giving an index on the acknowledge port. A level request stays up for as long as its input stays high. A write port loads the trigger-mode register. Each write is ANDed with a fixed per-instance parameter, so some lines can never be made level-triggered (for example 0xF8 on a primary unit and 0xDE on a secondary one).

For every rising sample on a line, the block reports a 2-bit status: newly latched, already pending (coalesced), or masked. Everything is sampled on the block clock. All outputs come from registers and change one clock after the sampling edge.

Top module: `irl_req_latch`

## Requirements
- R1: A synchronous active-high reset clears the request vector, the stored previous levels, the mask register and the trigger-mode register. A trigger mode of all zeros means every line is edge-triggered.
- R2: A line whose mode bit is 1 is level-triggered. Its request bit, one clock after a sampling edge, equals the line value sampled at that edge. The acknowledge port has no effect on it.
- R3: A line whose mode bit is 0 is edge-triggered. Its request bit is set when the sampled input is 1 and the stored previous level is 0. A line held high does not latch again after it has been acknowledged.
- R4: A low input never clears a pending edge-triggered request.
- R5: The stored previous level of every line is updated at every sampling edge, whatever its mode. A line that was high while level-triggered and is then switched to edge mode does not latch again until it has gone low and then high.
- R6: When ack_valid_i is 1, the request bit selected by ack_idx_i (a binary line number) is cleared, but only if that line is edge-triggered.
- R7: If an acknowledge and a rising edge reach the same edge-triggered line in the same cycle, the request stays set and the event is reported as newly latched.
- R8: A trigger-mode write stores mode_wdata AND WRITE_MASK (default 0xF8). Lines whose WRITE_MASK bit is 0 stay edge-triggered.
- R9: For each line that samples a rising transition, evt_valid_o is set for one cycle. Its code is in evt_code_o[2i+1:2i]: 2'b11 if the line's mask bit is set, otherwise 2'b10 if the request was already pending and was not being acknowledged, otherwise 2'b01. The code is 2'b00 where no event occurred. The request bit is 1 whenever the line's event is valid.
- R10: A mask write loads mask_wdata into the mask register, which is visible on mask_o. A set mask bit does not prevent the request from being latched.
- R11: All outputs are registered. They change only on the clock edge that samples the inputs causing the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | NUM_LINES | Synchronised interrupt input levels |
| mode_we | input | 1 | Trigger-mode register write strobe |
| mode_wdata | input | NUM_LINES | Trigger-mode write data (1 = level) |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | NUM_LINES | Mask write data (1 = masked) |
| ack_valid_i | input | 1 | Acknowledge strobe from priority logic |
| ack_idx_i | input | IDX_W | Binary index of line being acknowledged |
| req_o | output | NUM_LINES | Pending request vector |
| mode_o | output | NUM_LINES | Current trigger-mode register |
| mask_o | output | NUM_LINES | Current mask register |
| evt_valid_o | output | NUM_LINES | One-cycle event strobe per line |
| evt_code_o | output | 2*NUM_LINES | Per-line event status code |

## Verification
A stale previous-level bit shows up one clock later, either as a request that appears without a real rising edge or as a rising edge that is missed and leaves req_o low. A corrupted request bit shows up in two ways. It appears directly on req_o at the next edge, and it appears as a wrong coalesced-or-new code on the next event for that line. Cases where the mode or mask register affects the result are driven so that each one reaches the ports within one or two cycles. Those cases are a mode switch while a line is held high, an acknowledge that coincides with a new edge, and a reset while a line is asserted.

// File: rtl/irl_pkg.sv
package irl_pkg;

  localparam int unsigned CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    EVT_NONE   = 2'b00,
    EVT_NEW    = 2'b01,
    EVT_COAL   = 2'b10,
    EVT_MASKED = 2'b11
  } evt_code_t;

endpackage

// File: rtl/irl_cfg_regs.sv
module irl_cfg_regs #(
  parameter int unsigned NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0] WRITE_MASK = 8'hF8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_we,
  input  logic [NUM_LINES-1:0] mode_wdata,
  input  logic                 mask_we,
  input  logic [NUM_LINES-1:0] mask_wdata,
  output logic [NUM_LINES-1:0] mode_q,
  output logic [NUM_LINES-1:0] mask_q
);

  // Trigger mode: only bits allowed by WRITE_MASK can become level.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (mode_we) begin
      mode_q <= mode_wdata & WRITE_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= mask_wdata;
    end
  end

endmodule

// File: rtl/irl_ack_decode.sv
module irl_ack_decode #(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 ack_valid_i,
  input  logic [IDX_W-1:0]     ack_idx_i,
  output logic [NUM_LINES-1:0] ack_vec_o
);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_dec
    assign ack_vec_o[g] = ack_valid_i && (ack_idx_i == IDX_W'(g));
  end

endmodule

// File: rtl/irl_line_cell.sv
module irl_line_cell
  import irl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      line_i,
  input  logic      level_mode_i,
  input  logic      masked_i,
  input  logic      ack_i,
  output logic      req_o,
  output logic      evt_valid_o,
  output evt_code_t evt_code_o
);

  logic prev_q;
  logic req_q;
  logic rise;
  logic held;
  logic req_d;
  evt_code_t code_d;

  assign rise = line_i & ~prev_q;
  // A request counts as already pending only if it is not being consumed now.
  assign held = req_q & ~ack_i;

  always_comb begin
    if (level_mode_i) begin
      req_d = line_i;
    end else begin
      req_d = rise | held;
    end
  end

  always_comb begin
    if (!rise) begin
      code_d = EVT_NONE;
    end else if (masked_i) begin
      code_d = EVT_MASKED;
    end else if (held) begin
      code_d = EVT_COAL;
    end else begin
      code_d = EVT_NEW;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q      <= 1'b0;
      req_q       <= 1'b0;
      evt_valid_o <= 1'b0;
      evt_code_o  <= EVT_NONE;
    end else begin
      prev_q      <= line_i;
      req_q       <= req_d;
      evt_valid_o <= rise;
      evt_code_o  <= code_d;
    end
  end

  assign req_o = req_q;

endmodule

// File: rtl/irl_req_latch.sv
module irl_req_latch
  import irl_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0] WRITE_MASK = 8'hF8,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_LINES-1:0]        line_i,
  input  logic                        mode_we,
  input  logic [NUM_LINES-1:0]        mode_wdata,
  input  logic                        mask_we,
  input  logic [NUM_LINES-1:0]        mask_wdata,
  input  logic                        ack_valid_i,
  input  logic [IDX_W-1:0]            ack_idx_i,
  output logic [NUM_LINES-1:0]        req_o,
  output logic [NUM_LINES-1:0]        mode_o,
  output logic [NUM_LINES-1:0]        mask_o,
  output logic [NUM_LINES-1:0]        evt_valid_o,
  output logic [CODE_W*NUM_LINES-1:0] evt_code_o
);

  logic [NUM_LINES-1:0] mode_q;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] ack_vec;

  irl_cfg_regs #(
    .NUM_LINES (NUM_LINES),
    .WRITE_MASK(WRITE_MASK)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .mode_we   (mode_we),
    .mode_wdata(mode_wdata),
    .mask_we   (mask_we),
    .mask_wdata(mask_wdata),
    .mode_q    (mode_q),
    .mask_q    (mask_q)
  );

  irl_ack_decode #(
    .NUM_LINES(NUM_LINES)
  ) u_ack (
    .ack_valid_i(ack_valid_i),
    .ack_idx_i  (ack_idx_i),
    .ack_vec_o  (ack_vec)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    evt_code_t code_w;

    irl_line_cell u_cell (
      .clk         (clk),
      .rst         (rst),
      .line_i      (line_i[g]),
      .level_mode_i(mode_q[g]),
      .masked_i    (mask_q[g]),
      .ack_i       (ack_vec[g]),
      .req_o       (req_o[g]),
      .evt_valid_o (evt_valid_o[g]),
      .evt_code_o  (code_w)
    );

    assign evt_code_o[CODE_W*g +: CODE_W] = code_w;
  end

  assign mode_o = mode_q;
  assign mask_o = mask_q;

endmodule

// File: rtl/irl_req_latch_chk.sv
module irl_req_latch_chk #(
  parameter int unsigned NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0] WRITE_MASK = 8'hF8,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_LINES-1:0]   line_i,
  input logic                   mode_we,
  input logic [NUM_LINES-1:0]   mode_wdata,
  input logic                   ack_valid_i,
  input logic [IDX_W-1:0]       ack_idx_i,
  input logic [NUM_LINES-1:0]   req_o,
  input logic [NUM_LINES-1:0]   mode_o,
  input logic [NUM_LINES-1:0]   mask_o,
  input logic [NUM_LINES-1:0]   evt_valid_o,
  input logic [2*NUM_LINES-1:0] evt_code_o
);

  logic [NUM_LINES-1:0] ack_sel;
  always_comb begin
    ack_sel = '0;
    if (ack_valid_i) ack_sel[ack_idx_i] = 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (req_o == '0) && (mode_o == '0) && (mask_o == '0) && (evt_valid_o == '0)); // R1

  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (((req_o ^ $past(line_i)) & $past(mode_o)) == '0)); // R2

  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (($past(req_o) & ~$past(mode_o) & ~$past(ack_sel) & ~req_o) == '0)); // R4

  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (rst)
    mode_we |=> (mode_o == ($past(mode_wdata) & WRITE_MASK))); // R8

  AST_EVT_SETS_REQ: assert property (@(posedge clk) disable iff (rst)
    (evt_valid_o != '0) |-> ((evt_valid_o & ~req_o) == '0)); // R9

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
    AST_EVT_MASKED: assert property (@(posedge clk) disable iff (rst)
      $past(mask_o[g]) && evt_valid_o[g] |-> (evt_code_o[2*g +: 2] == 2'b11)); // R9
  end

endmodule

bind irl_req_latch irl_req_latch_chk #(
  .NUM_LINES (NUM_LINES),
  .WRITE_MASK(WRITE_MASK)
) u_irl_chk (
  .clk        (clk),
  .rst        (rst),
  .line_i     (line_i),
  .mode_we    (mode_we),
  .mode_wdata (mode_wdata),
  .ack_valid_i(ack_valid_i),
  .ack_idx_i  (ack_idx_i),
  .req_o      (req_o),
  .mode_o     (mode_o),
  .mask_o     (mask_o),
  .evt_valid_o(evt_valid_o),
  .evt_code_o (evt_code_o)
);

// File: tb/irl_req_latch_bench.sv
module irl_req_latch_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  line_i = '0;
  logic        mode_we = 1'b0;
  logic [7:0]  mode_wdata = '0;
  logic        mask_we = 1'b0;
  logic [7:0]  mask_wdata = '0;
  logic        ack_valid_i = 1'b0;
  logic [2:0]  ack_idx_i = '0;
  logic [7:0]  req_o;
  logic [7:0]  mode_o;
  logic [7:0]  mask_o;
  logic [7:0]  evt_valid_o;
  logic [15:0] evt_code_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  irl_req_latch u_irl_req_latch (
    .clk(clk), .rst(rst), .line_i(line_i),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .ack_valid_i(ack_valid_i), .ack_idx_i(ack_idx_i),
    .req_o(req_o), .mode_o(mode_o), .mask_o(mask_o),
    .evt_valid_o(evt_valid_o), .evt_code_o(evt_code_o)
  );

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // One cycle: drive on the falling edge, sample just after the rising edge.
  task automatic step(input logic [7:0] ln, input logic av, input logic [2:0] ai);
    @(negedge clk);
    line_i = ln; ack_valid_i = av; ack_idx_i = ai;
    mode_we = 1'b0; mask_we = 1'b0;
    @(posedge clk);
    #1;
  endtask

  // {line, ack_valid, ack_idx, exp_req, exp_evt, exp_code}; lines 4..7 level, line 7 masked
  localparam int NV = 15;
  localparam logic [43:0] VEC [NV] = '{
    {8'h01, 1'b0, 3'd0, 8'h01, 8'h01, 16'h0001}, // R3 rise latches new
    {8'h03, 1'b0, 3'd0, 8'h03, 8'h02, 16'h0004}, // R3
    {8'h00, 1'b0, 3'd0, 8'h03, 8'h00, 16'h0000}, // R4 low keeps edge request
    {8'h01, 1'b0, 3'd0, 8'h03, 8'h01, 16'h0002}, // R9 coalesced
    {8'h01, 1'b1, 3'd0, 8'h02, 8'h00, 16'h0000}, // R6 ack clears, R3 no relatch
    {8'h11, 1'b0, 3'd0, 8'h12, 8'h10, 16'h0100}, // R2 level high
    {8'h11, 1'b1, 3'd4, 8'h12, 8'h00, 16'h0000}, // R6 ack on level ignored
    {8'h01, 1'b0, 3'd0, 8'h02, 8'h00, 16'h0000}, // R2 level low clears
    {8'h80, 1'b0, 3'd0, 8'h82, 8'h80, 16'hC000}, // R10 masked still latched, R9 masked code
    {8'h81, 1'b1, 3'd1, 8'h81, 8'h01, 16'h0001}, // R6
    {8'h00, 1'b1, 3'd0, 8'h00, 8'h00, 16'h0000}, // R6
    {8'h04, 1'b1, 3'd2, 8'h04, 8'h04, 16'h0010}, // R7 ack plus rise -> new
    {8'h00, 1'b1, 3'd2, 8'h00, 8'h00, 16'h0000}, // R6
    {8'h0C, 1'b0, 3'd0, 8'h0C, 8'h0C, 16'h0050}, // R3 two lines
    {8'h08, 1'b1, 3'd2, 8'h08, 8'h00, 16'h0000}  // R4
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 req after reset", {8'h0, req_o}, 16'h0000);
    chk("R1 mode after reset", {8'h0, mode_o}, 16'h0000);
    @(negedge clk);
    rst = 1'b0;
    mode_we = 1'b1; mode_wdata = 8'hF0;
    mask_we = 1'b1; mask_wdata = 8'h80;
    @(posedge clk); #1;
    chk("R8 mode write", {8'h0, mode_o}, 16'h00F0);
    chk("R10 mask write", {8'h0, mask_o}, 16'h0080);

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      v = VEC[i];
      step(v[43:36], v[35], v[34:32]);
      chk($sformatf("R2/R3/R4/R6/R7 req row %0d", i), {8'h0, req_o}, {8'h0, v[31:24]});
      chk($sformatf("R9 evt row %0d", i), {8'h0, evt_valid_o}, {8'h0, v[23:16]});
      chk($sformatf("R9 code row %0d", i), evt_code_o, v[15:0]);
    end

    // R8: bits outside the write mask stay edge
    @(negedge clk);
    line_i = 8'h00; ack_valid_i = 1'b0;
    mode_we = 1'b1; mode_wdata = 8'hFF;
    @(posedge clk); #1;
    mode_we = 1'b0;
    chk("R8 masked mode write", {8'h0, mode_o}, 16'h00F8);
    chk("R4 edge held on low", {8'h0, req_o}, 16'h0008);

    // R11: no output change before the sampling edge
    @(negedge clk);
    line_i = 8'h10; ack_valid_i = 1'b1; ack_idx_i = 3'd3;
    #1;
    chk("R11 req before edge", {8'h0, req_o}, 16'h0008);
    @(posedge clk); #1;
    chk("R11 req after edge", {8'h0, req_o}, 16'h0010);

    // R5: previous level tracked while level-triggered
    @(negedge clk);
    ack_valid_i = 1'b0;
    mode_we = 1'b1; mode_wdata = 8'h00;
    @(posedge clk); #1;
    chk("R5 req while switching", {8'h0, req_o}, 16'h0010);
    step(8'h10, 1'b1, 3'd4);
    chk("R5 no relatch after mode switch", {8'h0, req_o}, 16'h0000);
    chk("R5 no event", {8'h0, evt_valid_o}, 16'h0000);

    // R10 mask readback
    @(negedge clk);
    ack_valid_i = 1'b0;
    mask_we = 1'b1; mask_wdata = 8'h5A;
    mode_we = 1'b1; mode_wdata = 8'h38;
    @(posedge clk); #1;
    chk("R10 mask readback", {8'h0, mask_o}, 16'h005A);
    chk("R8 mode 38", {8'h0, mode_o}, 16'h0038);

    // R1: reset mid-run, line still high
    @(negedge clk);
    mask_we = 1'b0; mode_we = 1'b0;
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 req cleared", {8'h0, req_o}, 16'h0000);
    chk("R1 mode cleared", {8'h0, mode_o}, 16'h0000);
    chk("R1 mask cleared", {8'h0, mask_o}, 16'h0000);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 prev cleared so held line latches", {8'h0, req_o}, 16'h0010);
    chk("R1 event after reset", evt_code_o, 16'h0100);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule